// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block tracks loads that a scheduler has moved above earlier stores whose addresses were unknown at compile time. When such an advanced load issues, it records its destination register tag, its byte address and its access size in a small fully associative table. Each later store compares its byte range against every live entry and kills any entry it overlaps. When the program reaches the load's original position, a check operation asks about the register tag. A surviving entry means the early value is still good. A killed or missing entry means recovery code must run.

A missing entry is treated the same as a killed one, so the table is free to drop entries when it runs out of room. A check may either leave its entry in place or remove it. A flush empties the whole table. Check results are registered and appear one cycle after the check is presented.

Top module: `ld_spec_table`

## Requirements
- R1: After synchronous reset the table holds no entries and `res_valid` is 0.
- R2: A check presented in cycle t yields `res_valid`=1 in cycle t+1. `res_ok` is 1 only if a live entry with the checked tag exists after the same-cycle store has been applied.
- R3: Sizes are encoded 0,1,2,3 for 1,2,4,8 bytes, and addresses are naturally aligned to their size. A store kills an entry when both fall in the same 8-byte word (address bits 63:3) and their byte lanes (address bits 2:0 through size) intersect. Disjoint lanes in the same word do not kill.
- R4: A check of a tag that has no live entry returns `res_ok`=0.
- R5: A load whose tag is already held overwrites that entry, so at most one entry per tag exists and only the newest address is tracked.
- R6: A load with a new tag takes the lowest-numbered free entry. When the table is full it evicts the entry selected by a round-robin pointer. The pointer starts at 0 and steps by one on each such eviction.
- R7: A check with `chk_clear`=0 leaves a live entry in place. A check with `chk_clear`=1 removes it.
- R8: A store and a check in the same cycle: the check sees the store's kills.
- R9: `flush` empties the table for the next cycle and overrides any load in the same cycle, which then neither inserts nor moves the pointer. A check in the flush cycle still sees the pre-flush contents.
- R10: A load and a store in the same cycle: the store kills older entries only, and the new entry stays live. Free and tag-match decisions use the contents at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| ld_valid | input | 1 | Advanced load records an entry |
| ld_tag | input | 7 | Destination register tag of the load |
| ld_addr | input | 64 | Load byte address |
| ld_size | input | 2 | Load size code |
| st_valid | input | 1 | Store probes the table |
| st_addr | input | 64 | Store byte address |
| st_size | input | 2 | Store size code |
| chk_valid | input | 1 | Check request |
| chk_tag | input | 7 | Register tag to check |
| chk_clear | input | 1 | Remove the entry on check |
| res_valid | output | 1 | Check result present |
| res_ok | output | 1 | 1 = speculation held, 0 = run recovery |

## Verification
The bench targets partial overlaps inside one 8-byte word. A design that compared whole addresses would miss a 2-byte store into the middle of an 8-byte load, and a design that compared only word addresses would wrongly kill loads on disjoint lanes. It fills the table past capacity to check the round-robin victim order and the rule that free slots are used first: a wrong pointer would drop a live entry and keep a stale one. Same-cycle pairings of store with check, load with store, flush with check, and flush with load expose ordering mistakes, such as a check that reports success for an entry the store just killed. Repeated loads to one tag catch designs that make duplicate entries, where a stale twin could answer a later check.

// File: rtl/ld_spec_pkg.sv
package ld_spec_pkg;
  localparam int TAG_W  = 7;
  localparam int ADDR_W = 64;
  localparam int SIZE_W = 2;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] addr;
    logic [SIZE_W-1:0] size;
  } ent_t;

  function automatic logic [7:0] lane_mask(input logic [2:0] lo, input logic [SIZE_W-1:0] sz);
    logic [7:0] base;
    case (sz)
      2'd0: base = 8'h01;
      2'd1: base = 8'h03;
      2'd2: base = 8'h0F;
      default: base = 8'hFF;
    endcase
    return base << lo;
  endfunction
endpackage

// File: rtl/ld_spec_cmp.sv
module ld_spec_cmp
  import ld_spec_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int TW = TAG_W
) (
  input  logic          live,
  input  logic [TW-1:0] e_tag,
  input  logic [AW-1:0] e_addr,
  input  logic [1:0]    e_size,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_size,
  input  logic [TW-1:0] chk_tag,
  input  logic [TW-1:0] ld_tag,
  output logic          st_kill,
  output logic          chk_hit,
  output logic          ld_hit
);
  logic same_word, lanes_meet;
  always_comb begin
    same_word  = (e_addr[AW-1:3] == st_addr[AW-1:3]);
    lanes_meet = |(lane_mask(e_addr[2:0], e_size) & lane_mask(st_addr[2:0], st_size));
    st_kill    = live && st_valid && same_word && lanes_meet;
    chk_hit    = live && (e_tag == chk_tag) && !st_kill;
    ld_hit     = live && (e_tag == ld_tag);
  end
endmodule

// File: rtl/ld_spec_alloc.sv
module ld_spec_alloc #(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               ld_valid,
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] tag_hit,
  output logic [ENTRIES-1:0] sel
);
  logic [IW-1:0] rr_ptr;
  logic [IW-1:0] free_idx;
  logic          any_free, any_hit, evict;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!live[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
    any_hit = |tag_hit;
    evict   = ld_valid && !any_hit && !any_free;
    sel     = '0;
    if (ld_valid) begin
      if (any_hit)       sel = tag_hit;
      else if (any_free) sel[free_idx] = 1'b1;
      else               sel[rr_ptr] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 rr_ptr <= '0;
    else if (evict && !flush) rr_ptr <= (rr_ptr == IW'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
  end

  assert_unique_tag_R5: assert property (@(posedge clk) disable iff (rst) $onehot0(tag_hit));
  assert_one_slot_R6: assert property (@(posedge clk) disable iff (rst) $onehot0(sel));
  assert_slot_taken_R6: assert property (@(posedge clk) disable iff (rst) ld_valid |-> $countones(sel) == 1);
endmodule

// File: rtl/ld_spec_table.sv
module ld_spec_table
  import ld_spec_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic              chk_clear,
  output logic              res_valid,
  output logic              res_ok
);
  logic [ENTRIES-1:0] live;
  ent_t               ent [ENTRIES];
  logic [ENTRIES-1:0] st_kill, chk_hit, ld_hit, ins_sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    ld_spec_cmp u_cmp (
      .live(live[g]), .e_tag(ent[g].tag), .e_addr(ent[g].addr), .e_size(ent[g].size),
      .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
      .chk_tag(chk_tag), .ld_tag(ld_tag),
      .st_kill(st_kill[g]), .chk_hit(chk_hit[g]), .ld_hit(ld_hit[g])
    );
  end

  ld_spec_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk(clk), .rst(rst), .flush(flush), .ld_valid(ld_valid),
    .live(live), .tag_hit(ld_hit), .sel(ins_sel)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst || flush)  live[g] <= 1'b0;
      else if (ins_sel[g]) live[g] <= 1'b1;
      else if (st_kill[g] || (chk_valid && chk_clear && chk_hit[g])) live[g] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (ins_sel[g]) ent[g] <= '{tag: ld_tag, addr: ld_addr, size: ld_size};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
    end else begin
      res_valid <= chk_valid;
      res_ok    <= chk_valid && (|chk_hit);
    end
  end

  assert_result_next_R2: assert property (@(posedge clk) disable iff (rst) chk_valid |=> res_valid);
  assert_idle_no_result_R2: assert property (@(posedge clk) disable iff (rst) !chk_valid |=> !res_valid);
  assert_ok_needs_valid_R4: assert property (@(posedge clk) disable iff (rst) res_ok |-> res_valid);
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst) flush |=> live == '0);
  assert_reset_empty_R1: assert property (@(posedge clk) $past(rst) |-> (live == '0 && !res_valid));
endmodule

// File: tb/ld_spec_table_tb.sv
module ld_spec_table_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 0, rst = 1, flush = 0;
  logic ld_valid = 0, st_valid = 0, chk_valid = 0, chk_clear = 0;
  logic [6:0] ld_tag = 0, chk_tag = 0;
  logic [63:0] ld_addr = 0, st_addr = 0;
  logic [1:0] ld_size = 0, st_size = 0;
  logic res_valid, res_ok;

  int compared = 0, mismatched = 0;
  bit m_live [N];
  logic [6:0] m_tag [N];
  logic [63:0] m_addr [N];
  logic [1:0] m_size [N];
  int m_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ld_spec_table #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst(rst), .flush(flush), .ld_valid(ld_valid), .ld_tag(ld_tag),
    .ld_addr(ld_addr), .ld_size(ld_size), .st_valid(st_valid), .st_addr(st_addr),
    .st_size(st_size), .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_clear(chk_clear),
    .res_valid(res_valid), .res_ok(res_ok)
  );

  function automatic logic [7:0] lanes(input logic [63:0] a, input logic [1:0] s);
    return 8'(((1 << (1 << s)) - 1) << a[2:0]);
  endfunction

  function automatic bit hits_store(input int i);
    return st_valid && m_live[i] && (m_addr[i][63:3] == st_addr[63:3]) &&
           ((lanes(m_addr[i], m_size[i]) & lanes(st_addr, st_size)) != 0);
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // One cycle: inputs already driven at the falling edge.
  task automatic step(input string req);
    bit kill [N];
    bit exp_ok = 0;
    int tgt = -1, hit = -1, fr = -1;
    for (int i = 0; i < N; i++) begin
      kill[i] = hits_store(i);
      if (chk_valid && m_live[i] && m_tag[i] == chk_tag && !kill[i]) exp_ok = 1;
      if (m_live[i] && m_tag[i] == ld_tag) hit = i;
    end
    for (int i = N - 1; i >= 0; i--) if (!m_live[i]) fr = i;
    @(posedge clk);
    #1;
    check(req, "res_valid", res_valid, chk_valid);
    if (chk_valid) check(req, "res_ok", res_ok, exp_ok);
    for (int i = 0; i < N; i++) begin
      if (kill[i]) m_live[i] = 0;
      if (chk_valid && chk_clear && m_live[i] && m_tag[i] == chk_tag) m_live[i] = 0;
    end
    if (flush) begin
      for (int i = 0; i < N; i++) m_live[i] = 0;
    end else if (ld_valid) begin
      if (hit >= 0) tgt = hit;
      else if (fr >= 0) tgt = fr;
      else begin tgt = m_ptr; m_ptr = (m_ptr + 1) % N; end
      m_live[tgt] = 1; m_tag[tgt] = ld_tag; m_addr[tgt] = ld_addr; m_size[tgt] = ld_size;
    end
    @(negedge clk);
    ld_valid = 0; st_valid = 0; chk_valid = 0; chk_clear = 0; flush = 0;
  endtask

  task automatic ld(input logic [6:0] t, input logic [63:0] a, input logic [1:0] s);
    ld_valid = 1; ld_tag = t; ld_addr = a; ld_size = s;
  endtask
  task automatic st(input logic [63:0] a, input logic [1:0] s);
    st_valid = 1; st_addr = a; st_size = s;
  endtask
  task automatic ck(input logic [6:0] t, input bit clr);
    chk_valid = 1; chk_tag = t; chk_clear = clr;
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1", "res_valid after reset", res_valid, 1'b0);
    ck(5, 0); step("R1 R4 empty table");
    // R2 and R7: hit survives a plain check
    ld(3, 64'h100, 3); step("R2");
    ck(3, 0); step("R2 hit");
    ck(3, 0); step("R7 entry kept");
    // R3: partial overlap kills, disjoint lanes do not
    st(64'h104, 1); step("R3");
    ck(3, 0); step("R3 overlap kill");
    ld(4, 64'h200, 2); step("R3");
    st(64'h204, 2); step("R3");
    ck(4, 0); step("R3 disjoint lanes");
    // R5: overwrite keeps one entry with newest address
    ld(6, 64'h300, 3); step("R5");
    ld(6, 64'h400, 3); step("R5");
    st(64'h300, 3); step("R5");
    ck(6, 0); step("R5 old address dropped");
    ck(6, 1); step("R7 clear check");
    ck(6, 0); step("R7 removed");
    // R8: store and check together
    ld(7, 64'h500, 0); step("R8");
    st(64'h500, 0); ck(7, 0); step("R8 same cycle");
    // R10: load and store together
    ld(8, 64'h600, 3); st(64'h600, 3); step("R10");
    ck(8, 0); step("R10 new entry lives");
    // R9: flush
    ld(9, 64'h700, 3); step("R9");
    flush = 1; ck(9, 0); step("R9 pre-flush view");
    ck(9, 0); step("R9 emptied");
    flush = 1; ld(2, 64'h800, 3); step("R9");
    ck(2, 0); step("R9 flush beats load");
    // R6: fill, evict round robin, prefer free slot
    for (int t = 10; t < 26; t++) begin ld(7'(t), 64'h1000 + 64'(t) * 8, 3); step("R6"); end
    ld(40, 64'h2000, 3); step("R6");
    ck(10, 0); step("R6 victim 0");
    ck(11, 0); step("R6 slot 1 kept");
    ld(41, 64'h2008, 3); step("R6");
    ck(11, 0); step("R6 victim 1");
    ck(20, 1); step("R6");
    ld(42, 64'h2010, 3); step("R6 free slot first");
    ck(12, 0); step("R6 slot 2 kept");
    ld(43, 64'h2018, 3); step("R6");
    ck(12, 0); step("R6 victim 2");
    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] s;
      if ($urandom_range(99) < 40) begin
        s = 2'($urandom_range(3));
        ld(7'($urandom_range(23)), {59'($urandom_range(3)), 5'd0} | (64'($urandom_range(7)) & ~((64'd1 << s) - 1)), s);
      end
      if ($urandom_range(99) < 25) begin
        s = 2'($urandom_range(3));
        st({59'($urandom_range(3)), 5'd0} | (64'($urandom_range(7)) & ~((64'd1 << s) - 1)), s);
      end
      if ($urandom_range(99) < 45) ck(7'($urandom_range(23)), $urandom_range(99) < 30);
      if ($urandom_range(99) < 1) flush = 1;
      step("R2 R3 R6 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule